// File: doc/BRIEF.md
# Multicast Tree Routing Table

This block sits beside the input stage of one router in a 4x4 mesh and turns the head flit of that input into switch requests. The router has five outputs. Each output has a fixed bit position in every request or grant mask: bit 0 is local delivery (eject), bit 1 is North, bit 2 is South, bit 3 is East and bit 4 is West. Node numbers are `y*MESH_X + x`. North means a smaller y and West means a smaller x. Ordinary point-to-point flits are routed by dimension order: X is corrected first, then Y, and the flit is delivered locally once both coordinates match this router.

Multicast trees are kept in a table of port masks, one entry for every pair of source node and tree number. A tree is built by a series of ordinary point-to-point setup flits that all carry the same tree number. As each setup flit leaves this router, the output it was routed to is merged into the entry. A multicast data flit reads its entry and raises one request per set bit. Each branch is served as soon as its own output is granted, whatever happens on the other branches, and the flit leaves the buffer only when every branch has been served. Buffers and allocators are outside this block: they appear only as a grant mask and a pop strobe.

Top module: `mtr_router_table`

## Requirements
- R1: After reset every table entry is empty. A multicast flit that reads an empty entry raises no request and pops in the same cycle.
- R2: A point-to-point flit (kind 2'b00, or the unused code 2'b11) requests exactly one output, chosen by the X-then-Y rule. It pops in the cycle that output is granted and stays in place while it is not granted.
- R3: A setup flit (kind 2'b01) is routed like R2. In the cycle it pops, the bit of its output is set in the entry selected by (source, tree) and every bit already set is kept.
- R4: A setup flit whose destination is this router requests eject (bit 0) and adds the eject bit to the entry.
- R5: A multicast data flit (kind 2'b10) requests every output whose bit is set in its entry.
- R6: Under partial grants, the granted branches drop out of the request from the next cycle on and the ungranted branches stay requested.
- R7: A multicast flit pops in the cycle its last outstanding branch is granted, and not before.
- R8: A setup flit whose generation bit differs from the one stored in the entry clears the old mask before adding its own bit, and it stores the new generation.
- R9: Point-to-point and multicast data flits never change a table entry.
- R10: Entries are independent. A write to one (source, tree) pair is not visible in any other pair.
- R11: Grant bits on outputs that are not requested have no effect. With no valid flit, the block raises no request and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A head flit is present |
| in_kind | input | 2 | 00 point-to-point, 01 setup, 10 multicast data, 11 treated as 00 |
| in_src | input | 4 | Source node of the tree |
| in_tree | input | 6 | Tree number within the source |
| in_dest | input | 4 | Destination node (point-to-point and setup) |
| in_gen | input | 1 | Generation bit carried by setup flits |
| out_grant | input | 5 | Per-output grant from the switch allocator |
| out_req | output | 5 | Per-output switch request |
| in_pop | output | 1 | The head flit leaves the input buffer |

## Verification
Two functions can fall in the same cycle: a setup flit writes the table as it departs, and the very next flit reads that same entry for a multicast. The bench sends the multicast data flit in the cycle right after the last setup flit, and it checks that the requested mask already holds the bit that was just added. Generation replacement is tested the same way: a setup flit with the flipped generation is followed at once by a multicast read, which must show only the new bit. The second overlap is a partial grant arriving in the cycle a branch is loaded from the table. The bench judges this by the exact request mask it sees on each later cycle and by the cycle in which the pop occurs.

// File: rtl/mtr_pkg.sv
// Shared constants and types for the multicast tree routing table.
// Assumes a five-output router; output bit positions are fixed here.
package mtr_pkg;
    localparam int NPORT  = 5;
    localparam int P_EJ   = 0;
    localparam int P_NORTH = 1;
    localparam int P_SOUTH = 2;
    localparam int P_EAST  = 3;
    localparam int P_WEST  = 4;

    typedef enum logic [1:0] {
        K_UNI   = 2'b00,
        K_SETUP = 2'b01,
        K_MCAST = 2'b10,
        K_RSVD  = 2'b11
    } flit_kind_e;

    typedef struct packed {
        logic             gen;
        logic [NPORT-1:0] mask;
    } tree_entry_t;
endpackage

// File: rtl/mtr_xy_route.sv
// X-then-Y route computation for one router of a mesh.
// Assumes node id = y*MESH_X + x; North lowers y, West lowers x.
module mtr_xy_route
    import mtr_pkg::*;
#(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1,
    parameter int NODE_W = $clog2(MESH_X * MESH_Y)
) (
    input  logic [NODE_W-1:0] dest_i,
    output logic [NPORT-1:0]  port_o
);
    // Pick one output: correct X first, then Y, else eject.
    always_comb begin
        int dx;
        int dy;
        dx = int'(dest_i) % MESH_X;
        dy = int'(dest_i) / MESH_X;
        port_o = '0;
        if (dx > MY_X)      port_o[P_EAST]  = 1'b1;
        else if (dx < MY_X) port_o[P_WEST]  = 1'b1;
        else if (dy > MY_Y) port_o[P_SOUTH] = 1'b1;
        else if (dy < MY_Y) port_o[P_NORTH] = 1'b1;
        else                port_o[P_EJ]    = 1'b1;
    end
endmodule

// File: rtl/mtr_tree_store.sv
// Table of tree port masks, one entry per (source, tree) pair.
// Read is combinational; a write merges one port bit and may clear
// the old mask when the generation bit differs.
module mtr_tree_store
    import mtr_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_en_i,
    input  logic             wr_gen_i,
    input  logic [NPORT-1:0] wr_bit_i,
    output logic [NPORT-1:0] rd_mask_o
);
    tree_entry_t mem [ENTRIES];

    // Combinational read of the addressed entry.
    assign rd_mask_o = mem[idx_i].mask;

    // Clear all entries on reset; merge or replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en_i) begin
            if (mem[idx_i].gen != wr_gen_i)
                mem[idx_i].mask <= wr_bit_i;
            else
                mem[idx_i].mask <= mem[idx_i].mask | wr_bit_i;
            mem[idx_i].gen <= wr_gen_i;
        end
    end

    // R3
    bit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((mem[$past(idx_i)].mask & $past(wr_bit_i)) == $past(wr_bit_i)));

    // R8
    gen_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (mem[idx_i].gen != wr_gen_i))
        |=> (mem[$past(idx_i)].mask == $past(wr_bit_i)));
endmodule

// File: rtl/mtr_branch_track.sv
// Tracks the branches of a multicast head flit that are still unserved.
// Assumes the head flit stays in place until done_o is high.
module mtr_branch_track
    import mtr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [NPORT-1:0] fresh_mask_i,
    input  logic [NPORT-1:0] grant_i,
    output logic [NPORT-1:0] req_o,
    output logic             done_o
);
    logic [NPORT-1:0] pend_q;
    logic             live_q;
    logic [NPORT-1:0] left;

    // Fresh flits use the table mask; a flit in progress uses its pending mask.
    always_comb begin
        req_o  = live_q ? pend_q : fresh_mask_i;
        left   = req_o & ~grant_i;
        done_o = valid_i && (left == '0);
    end

    // Hold the unserved branches until all are granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            live_q <= 1'b0;
        end else if (valid_i) begin
            live_q <= (left != '0);
            pend_q <= left;
        end
    end

    // R6
    no_regrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && valid_i && !done_o) |=> ((pend_q & ~$past(pend_q)) == '0));

    // R7
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !live_q);
endmodule

// File: rtl/mtr_router_table.sv
// Multicast tree routing table for one mesh router input.
// Point-to-point and setup flits route by X-then-Y; setup flits merge
// their output into the tree entry as they depart; multicast data
// flits request all outputs of their tree and pop once every branch is served.
module mtr_router_table
    import mtr_pkg::*;
#(
    parameter int MESH_X        = 4,
    parameter int MESH_Y        = 4,
    parameter int MY_X          = 1,
    parameter int MY_Y          = 1,
    parameter int TREES_PER_SRC = 64,
    localparam int NODES   = MESH_X * MESH_Y,
    localparam int NODE_W  = $clog2(NODES),
    localparam int TREE_W  = $clog2(TREES_PER_SRC),
    localparam int ENTRIES = NODES * TREES_PER_SRC,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [NODE_W-1:0] in_src,
    input  logic [TREE_W-1:0] in_tree,
    input  logic [NODE_W-1:0] in_dest,
    input  logic              in_gen,
    input  logic [4:0]        out_grant,
    output logic [4:0]        out_req,
    output logic              in_pop
);
    logic             is_setup;
    logic             is_mcast;
    logic [NPORT-1:0] xy_port;
    logic [NPORT-1:0] tbl_mask;
    logic [NPORT-1:0] trk_req;
    logic             trk_done;
    logic [IDX_W-1:0] tbl_idx;
    logic             tbl_wr;

    // Decode the flit kind; the unused code routes as point-to-point.
    always_comb begin
        is_setup = in_kind == K_SETUP;
        is_mcast = in_kind == K_MCAST;
        tbl_idx  = IDX_W'(in_src) * IDX_W'(TREES_PER_SRC) + IDX_W'(in_tree);
    end

    mtr_xy_route #(
        .MESH_X(MESH_X), .MESH_Y(MESH_Y), .MY_X(MY_X), .MY_Y(MY_Y), .NODE_W(NODE_W)
    ) u_xy (
        .dest_i (in_dest),
        .port_o (xy_port)
    );

    mtr_tree_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_i     (tbl_idx),
        .wr_en_i   (tbl_wr),
        .wr_gen_i  (in_gen),
        .wr_bit_i  (xy_port),
        .rd_mask_o (tbl_mask)
    );

    mtr_branch_track u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_i      (in_valid && is_mcast),
        .fresh_mask_i (tbl_mask),
        .grant_i      (out_grant),
        .req_o        (trk_req),
        .done_o       (trk_done)
    );

    // Select the request source and the pop condition by flit kind.
    always_comb begin
        if (!in_valid) begin
            out_req = '0;
            in_pop  = 1'b0;
        end else if (is_mcast) begin
            out_req = trk_req;
            in_pop  = trk_done;
        end else begin
            out_req = xy_port;
            in_pop  = (xy_port & out_grant) != '0;
        end
        tbl_wr = in_pop && is_setup;
    end

    // R2
    uni_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_mcast) |-> ($countones(out_req) == 1));

    // R11
    pop_needs_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |-> in_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_req == '0));
endmodule

// File: tb/mtr_router_table_test.sv
// Vector-driven bench for mtr_router_table (router at x=1, y=1, node 5).
module mtr_router_table_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_kind = 2'b00;
    logic [3:0] in_src = '0;
    logic [5:0] in_tree = '0;
    logic [3:0] in_dest = '0;
    logic       in_gen = 1'b0;
    logic [4:0] out_grant = '0;
    logic [4:0] out_req;
    logic       in_pop;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    mtr_router_table uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_src(in_src), .in_tree(in_tree), .in_dest(in_dest), .in_gen(in_gen),
        .out_grant(out_grant), .out_req(out_req), .in_pop(in_pop)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] kind;
        logic [3:0] src;
        logic [5:0] tree;
        logic [3:0] dest;
        logic       gen;
        logic [4:0] gnt;
        logic [4:0] ereq;
        logic       epop;
        logic [3:0] rq;
    } vec_t;

    // bits: 0 eject, 1 North, 2 South, 3 East, 4 West
    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'b00, 4'd3, 6'd7, 4'd6, 1'b0, 5'b00000, 5'b01000, 1'b0, 4'd2},  // R2 East held
        '{1'b1, 2'b00, 4'd3, 6'd7, 4'd6, 1'b0, 5'b01000, 5'b01000, 1'b1, 4'd2},  // R2 East pops
        '{1'b1, 2'b11, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b10000, 1'b1, 4'd2},  // R2 West, unused code
        '{1'b1, 2'b00, 4'd3, 6'd7, 4'd1, 1'b0, 5'b11111, 5'b00010, 1'b1, 4'd2},  // R2 North
        '{1'b1, 2'b00, 4'd3, 6'd7, 4'd9, 1'b0, 5'b11111, 5'b00100, 1'b1, 4'd2},  // R2 South
        '{1'b1, 2'b00, 4'd3, 6'd7, 4'd5, 1'b0, 5'b11111, 5'b00001, 1'b1, 4'd2},  // R2 eject
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b00000, 1'b1, 4'd9},  // R9 R1 still empty
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd6, 1'b0, 5'b00000, 5'b01000, 1'b0, 4'd3},  // R3 setup held
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd6, 1'b0, 5'b01000, 5'b01000, 1'b1, 4'd3},  // R3 setup East
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd9, 1'b0, 5'b11111, 5'b00100, 1'b1, 4'd3},  // R3 setup South
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd5, 1'b0, 5'b11111, 5'b00001, 1'b1, 4'd4},  // R4 setup eject
        '{1'b1, 2'b01, 4'd3, 6'd8, 4'd0, 1'b0, 5'b11111, 5'b10000, 1'b1, 4'd3},  // R3 other tree
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00000, 5'b01101, 1'b0, 4'd5},  // R5 full tree
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00100, 5'b01101, 1'b0, 4'd6},  // R6 South served
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b01000, 5'b01001, 1'b0, 4'd6},  // R6 East served
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00001, 5'b00001, 1'b1, 4'd7},  // R7 last branch
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b01101, 1'b1, 4'd9},  // R9 table unchanged
        '{1'b1, 2'b10, 4'd3, 6'd8, 4'd0, 1'b0, 5'b11111, 5'b10000, 1'b1, 4'd10}, // R10 tree 8
        '{1'b1, 2'b10, 4'd4, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b00000, 1'b1, 4'd10}, // R10 other source
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd1, 1'b1, 5'b11111, 5'b00010, 1'b1, 4'd8},  // R8 new generation
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b00010, 1'b1, 4'd8},  // R8 old tree gone
        '{1'b1, 2'b01, 4'd3, 6'd7, 4'd4, 1'b1, 5'b11111, 5'b10000, 1'b1, 4'd3},  // R3 same gen adds
        '{1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b10010, 1'b1, 4'd3},  // R3 merged tree
        '{1'b0, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b11111, 5'b00000, 1'b0, 4'd11}  // R11 idle
    };

    task automatic check(input int rq, input logic [4:0] ereq, input logic epop);
        checks++;
        if (out_req !== ereq) begin
            fails++;
            $display("FAIL R%0d out_req actual=%b expected=%b", rq, out_req, ereq);
        end
        checks++;
        if (in_pop !== epop) begin
            fails++;
            $display("FAIL R%0d in_pop actual=%b expected=%b", rq, in_pop, epop);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [3:0] s,
                         input logic [5:0] t, input logic [3:0] d, input logic g,
                         input logic [4:0] gn);
        @(negedge clk);
        in_valid = v; in_kind = k; in_src = s; in_tree = t;
        in_dest = d; in_gen = g; out_grant = gn;
        #2;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'b00, 4'd0, 6'd0, 4'd0, 1'b0, 5'b00000);
        check(11, 5'b00000, 1'b0);                         // R11 reset idle
        drive(1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00000);
        check(1, 5'b00000, 1'b1);                          // R1 empty after reset
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].v, VEC[i].kind, VEC[i].src, VEC[i].tree,
                  VEC[i].dest, VEC[i].gen, VEC[i].gnt);
            check(int'(VEC[i].rq), VEC[i].ereq, VEC[i].epop);
        end
        // R6 partial grant, then reset mid-flit clears the pending branches and the table (R1)
        drive(1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00010);
        check(6, 5'b10010, 1'b0);
        drive(1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00000);
        check(6, 5'b10000, 1'b0);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 2'b10, 4'd3, 6'd7, 4'd0, 1'b0, 5'b00000);
        check(1, 5'b00000, 1'b1);
        // R4 setup to self then immediate read of the entry
        drive(1'b1, 2'b01, 4'd15, 6'd63, 4'd5, 1'b0, 5'b00001);
        check(4, 5'b00001, 1'b1);
        drive(1'b1, 2'b10, 4'd15, 6'd63, 4'd0, 1'b0, 5'b00000);
        check(4, 5'b00001, 1'b0);
        drive(1'b1, 2'b10, 4'd15, 6'd63, 4'd0, 1'b0, 5'b11110);
        check(11, 5'b00001, 1'b0);                         // R11 unrequested grants ignored
        drive(1'b1, 2'b10, 4'd15, 6'd63, 4'd0, 1'b0, 5'b00001);
        check(7, 5'b00001, 1'b1);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule